// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Generator

This block produces the maintenance status of a virtual interrupt controller interface. It takes the following inputs:

- seven per-cause enable bits set by the hypervisor;
- the two group enables of the virtual CPU interface;
- an array of list-register entries, each with a 2-bit state code, a hardware flag and an end-of-interrupt-request flag;
- an end-of-interrupt counter.

From these it forms an 8-bit cause byte. The cause byte and a single maintenance interrupt line are both registered. The cause byte is presented zero-extended as a 64-bit read-only status word.

A separate decoder decides what a system-register read of the status word returns at each privilege level. It returns one of three results: the data, an undefined-instruction result, or a trap with a target level and a 6-bit syndrome code.

Hypervisor software uses the interrupt line to learn when the list registers need attention. It then reads the status word to find out which conditions are present.

Top module: `vmaint_status_gen`

## Requirements
- R1: `status_word` is 64 bits wide and bits 63:8 always read 0. The cause bits are laid out from bit 7 down to bit 0 as:
  - group-1-off;
  - group-1-on;
  - group-0-off;
  - group-0-on;
  - nothing-pending;
  - count-nonzero;
  - underflow;
  - end-of-interrupt.
- R2: Bit 7 is 1 when `en_g1_off`=1 and `vgrp1_on`=0. Bit 6 is 1 when `en_g1_on`=1 and `vgrp1_on`=1.
- R3: Bit 5 is 1 when `en_g0_off`=1 and `vgrp0_on`=0. Bit 4 is 1 when `en_g0_on`=1 and `vgrp0_on`=1.
- R4: Bit 3 is 1 when `en_nopend`=1 and no entry is pending. Entry i has its state code in `lr_state[2i+1:2i]`, with codes 00 invalid, 01 pending, 10 active and 11 pending-and-active. Codes 01 and 11 count as pending.
- R5: Bit 2 is 1 when `en_cnt_nz`=1 and `eoi_count` is nonzero.
- R6: Bit 1 is 1 when `en_underflow`=1 and at most one entry has a non-zero state code.
- R7: Bit 0 is 1 when at least one entry has state 00, `lr_hw[i]`=0 and `lr_eoi_req[i]`=1. This bit has no enable.
- R8: `maint_irq` is `maint_en` AND the OR of the eight cause bits. Both `maint_irq` and `status_word` follow their inputs one clock later.
- R9: While `rst_n` is low, `status_word` and `maint_irq` are 0.
- R10: When `rd_priv`=0, the read result is undefined (`rd_result`=1) and `rd_data` is 0.
- R11: When `rd_priv`=1, the read traps (`rd_result`=2) to level 2 with `rd_syndrome`=0x18 if `nest_trap` is 1. Otherwise the result is undefined.
- R12: When `rd_priv` is 2 or 3, the read traps to that same level with syndrome 0x18 if the enable for that level (`sre_hyp` or `sre_mon`) is 0. Otherwise `rd_result`=0 and `rd_data` equals `status_word`. `rd_syndrome` and `rd_trap_level` are 0 unless the read traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_g1_off | input | 1 | Enable for the group-1-off cause |
| en_g1_on | input | 1 | Enable for the group-1-on cause |
| en_g0_off | input | 1 | Enable for the group-0-off cause |
| en_g0_on | input | 1 | Enable for the group-0-on cause |
| en_nopend | input | 1 | Enable for the nothing-pending cause |
| en_cnt_nz | input | 1 | Enable for the count-nonzero cause |
| en_underflow | input | 1 | Enable for the underflow cause |
| vgrp0_on | input | 1 | Virtual group 0 enable |
| vgrp1_on | input | 1 | Virtual group 1 enable |
| lr_state | input | 2*N_LR | Packed state codes, two bits per entry |
| lr_hw | input | N_LR | Per-entry hardware flag |
| lr_eoi_req | input | N_LR | Per-entry end-of-interrupt request flag |
| eoi_count | input | CNT_W | End-of-interrupt counter |
| maint_en | input | 1 | Global maintenance interrupt enable |
| rd_priv | input | 2 | Privilege level of the read (0..3) |
| nest_trap | input | 1 | Nested-virtualisation trap control |
| sre_hyp | input | 1 | System-register enable at level 2 |
| sre_mon | input | 1 | System-register enable at level 3 |
| rd_result | output | 2 | 0 data, 1 undefined, 2 trap |
| rd_trap_level | output | 2 | Target level of a trap |
| rd_syndrome | output | 6 | Trap syndrome code |
| rd_data | output | 64 | Read data, zero unless the read succeeds |
| status_word | output | 64 | Registered status word |
| maint_irq | output | 1 | Registered maintenance interrupt |

## Verification
A read decoded at level 2 or 3 can fall in the same cycle as an input change that alters the cause byte. The bench provokes this by changing an enable at the falling edge while a permitted read is held.

Just before the next rising edge, the read must still return the old word. After that edge it must return the new word.

The same sampling separates the one-cycle latency of `maint_irq` from the moment `maint_en` is switched.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;

   localparam int STATUS_W = 64;
   localparam int CAUSE_W  = 8;

   // cause bit positions inside the status word
   localparam int B_G1_OFF   = 7;
   localparam int B_G1_ON    = 6;
   localparam int B_G0_OFF   = 5;
   localparam int B_G0_ON    = 4;
   localparam int B_NOPEND   = 3;
   localparam int B_CNT_NZ   = 2;
   localparam int B_UNDERFL  = 1;
   localparam int B_EOI      = 0;

   localparam logic [5:0] SYSREG_TRAP_SYN = 6'h18;

   typedef enum logic [1:0] {
      LR_INVALID  = 2'b00,
      LR_PENDING  = 2'b01,
      LR_ACTIVE   = 2'b10,
      LR_PEND_ACT = 2'b11
   } lr_state_e;

   typedef enum logic [1:0] {
      PRIV_USER   = 2'd0,
      PRIV_KERNEL = 2'd1,
      PRIV_HYP    = 2'd2,
      PRIV_MON    = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      RD_OK    = 2'd0,
      RD_UNDEF = 2'd1,
      RD_TRAP  = 2'd2
   } rd_res_e;

   typedef struct packed {
      logic g1_off;
      logic g1_on;
      logic g0_off;
      logic g0_on;
      logic nopend;
      logic cnt_nz;
      logic underflow;
   } cause_en_t;

endpackage

// File: rtl/vmaint_lr_scan.sv
module vmaint_lr_scan
   import vmaint_pkg::*;
#(
   parameter int N_LR     = 4,
   parameter int PAIR_MAX = 4
) (
   input  logic [2*N_LR-1:0] lr_state,
   input  logic [N_LR-1:0]   lr_hw,
   input  logic [N_LR-1:0]   lr_eoi_req,
   output logic [N_LR-1:0]   eoi_vec,
   output logic              none_pending,
   output logic              few_valid
);

   localparam int VCNT_W = $clog2(N_LR + 1);

   logic [N_LR-1:0] pend_vec;
   logic [N_LR-1:0] valid_vec;

   generate
      for (genvar i = 0; i < N_LR; i++) begin : g_entry
         lr_state_e st;
         assign st           = lr_state_e'(lr_state[2*i +: 2]);
         assign pend_vec[i]  = (st == LR_PENDING) || (st == LR_PEND_ACT);
         assign valid_vec[i] = (st != LR_INVALID);
         assign eoi_vec[i]   = (st == LR_INVALID) && !lr_hw[i] && lr_eoi_req[i];
      end
   endgenerate

   assign none_pending = ~|pend_vec;

   generate
      if (N_LR <= PAIR_MAX) begin : g_pairwise
         // small arrays: detect any two valid entries directly
         logic two_valid;
         always_comb begin
            two_valid = 1'b0;
            for (int a = 0; a < N_LR; a++) begin
               for (int b = a + 1; b < N_LR; b++) begin
                  two_valid = two_valid | (valid_vec[a] & valid_vec[b]);
               end
            end
         end
         assign few_valid = !two_valid;
      end else begin : g_counted
         // larger arrays: population count then compare
         logic [VCNT_W-1:0] vcnt;
         always_comb begin
            vcnt = '0;
            for (int k = 0; k < N_LR; k++) begin
               vcnt = vcnt + VCNT_W'(valid_vec[k]);
            end
         end
         assign few_valid = (vcnt <= VCNT_W'(1));
      end
   endgenerate

endmodule

// File: rtl/vmaint_cause.sv
module vmaint_cause
   import vmaint_pkg::*;
(
   input  cause_en_t            en,
   input  logic                 vgrp0_on,
   input  logic                 vgrp1_on,
   input  logic                 none_pending,
   input  logic                 few_valid,
   input  logic                 cnt_nonzero,
   input  logic                 any_eoi,
   output logic [CAUSE_W-1:0]   cause
);

   always_comb begin
      cause            = '0;
      cause[B_G1_OFF]  = en.g1_off    && !vgrp1_on;
      cause[B_G1_ON]   = en.g1_on     &&  vgrp1_on;
      cause[B_G0_OFF]  = en.g0_off    && !vgrp0_on;
      cause[B_G0_ON]   = en.g0_on     &&  vgrp0_on;
      cause[B_NOPEND]  = en.nopend    &&  none_pending;
      cause[B_CNT_NZ]  = en.cnt_nz    &&  cnt_nonzero;
      cause[B_UNDERFL] = en.underflow &&  few_valid;
      cause[B_EOI]     = any_eoi;
   end

endmodule

// File: rtl/vmaint_access.sv
module vmaint_access
   import vmaint_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          rd_priv,
   input  logic                nest_trap,
   input  logic                sre_hyp,
   input  logic                sre_mon,
   input  logic [STATUS_W-1:0] word,
   output logic [1:0]          rd_result,
   output logic [1:0]          rd_trap_level,
   output logic [5:0]          rd_syndrome,
   output logic [STATUS_W-1:0] rd_data
);

   rd_res_e res;
   logic [1:0] lvl;

   always_comb begin
      res = RD_UNDEF;
      lvl = 2'd0;
      unique case (priv_e'(rd_priv))
         PRIV_USER:   res = RD_UNDEF;
         PRIV_KERNEL: begin
            if (nest_trap) begin
               res = RD_TRAP;
               lvl = 2'(PRIV_HYP);
            end
         end
         PRIV_HYP: begin
            if (!sre_hyp) begin
               res = RD_TRAP;
               lvl = 2'(PRIV_HYP);
            end else begin
               res = RD_OK;
            end
         end
         PRIV_MON: begin
            if (!sre_mon) begin
               res = RD_TRAP;
               lvl = 2'(PRIV_MON);
            end else begin
               res = RD_OK;
            end
         end
         default: res = RD_UNDEF;
      endcase
   end

   assign rd_result     = res;
   assign rd_trap_level = lvl;
   assign rd_syndrome   = (res == RD_TRAP) ? SYSREG_TRAP_SYN : 6'd0;
   assign rd_data       = (res == RD_OK) ? word : '0;

   p_user_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_priv == 2'd0) |-> (rd_result == 2'(RD_UNDEF) && rd_data == '0));

   p_trap_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_result == 2'(RD_TRAP)) |-> (rd_trap_level >= 2'd2 && rd_syndrome == 6'h18));

   p_ok_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_result == 2'(RD_OK)) |-> (rd_priv >= 2'd2));

endmodule

// File: rtl/vmaint_status_gen.sv
module vmaint_status_gen
   import vmaint_pkg::*;
#(
   parameter int N_LR     = 4,
   parameter int CNT_W    = 5,
   parameter int PAIR_MAX = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_g1_off,
   input  logic                 en_g1_on,
   input  logic                 en_g0_off,
   input  logic                 en_g0_on,
   input  logic                 en_nopend,
   input  logic                 en_cnt_nz,
   input  logic                 en_underflow,
   input  logic                 vgrp0_on,
   input  logic                 vgrp1_on,
   input  logic [2*N_LR-1:0]    lr_state,
   input  logic [N_LR-1:0]      lr_hw,
   input  logic [N_LR-1:0]      lr_eoi_req,
   input  logic [CNT_W-1:0]     eoi_count,
   input  logic                 maint_en,
   input  logic [1:0]           rd_priv,
   input  logic                 nest_trap,
   input  logic                 sre_hyp,
   input  logic                 sre_mon,
   output logic [1:0]           rd_result,
   output logic [1:0]           rd_trap_level,
   output logic [5:0]           rd_syndrome,
   output logic [63:0]          rd_data,
   output logic [63:0]          status_word,
   output logic                 maint_irq
);

   localparam int PAD_W = STATUS_W - CAUSE_W;

   generate
      if (N_LR < 1 || N_LR > 16) begin : g_bad_nlr
         $error("vmaint_status_gen: N_LR must lie in 1..16");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("vmaint_status_gen: CNT_W must be at least 1");
      end
      if (PAIR_MAX < 1) begin : g_bad_pair
         $error("vmaint_status_gen: PAIR_MAX must be at least 1");
      end
   endgenerate

   logic [N_LR-1:0]    eoi_vec;
   logic               none_pend;
   logic               few_valid;
   logic [CAUSE_W-1:0] cause_d;
   logic [CAUSE_W-1:0] cause_q;
   logic               irq_q;
   cause_en_t          en;

   assign en = '{g1_off: en_g1_off, g1_on: en_g1_on, g0_off: en_g0_off,
                 g0_on: en_g0_on, nopend: en_nopend, cnt_nz: en_cnt_nz,
                 underflow: en_underflow};

   vmaint_lr_scan #(.N_LR(N_LR), .PAIR_MAX(PAIR_MAX)) u_scan (
      .lr_state     (lr_state),
      .lr_hw        (lr_hw),
      .lr_eoi_req   (lr_eoi_req),
      .eoi_vec      (eoi_vec),
      .none_pending (none_pend),
      .few_valid    (few_valid)
   );

   vmaint_cause u_cause (
      .en           (en),
      .vgrp0_on     (vgrp0_on),
      .vgrp1_on     (vgrp1_on),
      .none_pending (none_pend),
      .few_valid    (few_valid),
      .cnt_nonzero  (|eoi_count),
      .any_eoi      (|eoi_vec),
      .cause        (cause_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         cause_q <= cause_d;
         irq_q   <= maint_en && (|cause_d);
      end
   end

   assign status_word = {{PAD_W{1'b0}}, cause_q};
   assign maint_irq   = irq_q;

   vmaint_access u_access (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_priv       (rd_priv),
      .nest_trap     (nest_trap),
      .sre_hyp       (sre_hyp),
      .sre_mon       (sre_mon),
      .word          (status_word),
      .rd_result     (rd_result),
      .rd_trap_level (rd_trap_level),
      .rd_syndrome   (rd_syndrome),
      .rd_data       (rd_data)
   );

   p_g1_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_g1_off && !vgrp1_on) |=> status_word[7]);

   p_g0_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_g0_on && vgrp0_on) |=> status_word[4]);

   p_nopend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_nopend && none_pend) |=> status_word[3]);

   p_cnt_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cnt_nz && eoi_count != '0) |=> status_word[2]);

   p_underflow_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_underflow |=> !status_word[1]);

   p_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|eoi_vec) |=> status_word[0]);

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !maint_en |=> !maint_irq);

   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      maint_irq |-> (status_word[7:0] != 8'd0));

endmodule

// File: tb/sim_vmaint_status_gen.sv
module sim_vmaint_status_gen;

   localparam int N  = 4;
   localparam int CW = 5;

   logic clk = 1'b0;
   logic rst_n;
   logic en_g1_off, en_g1_on, en_g0_off, en_g0_on;
   logic en_nopend, en_cnt_nz, en_underflow;
   logic vgrp0_on, vgrp1_on;
   logic [2*N-1:0] lr_state;
   logic [N-1:0]   lr_hw, lr_eoi_req;
   logic [CW-1:0]  eoi_count;
   logic           maint_en;
   logic [1:0]     rd_priv;
   logic           nest_trap, sre_hyp, sre_mon;
   logic [1:0]     rd_result, rd_trap_level;
   logic [5:0]     rd_syndrome;
   logic [63:0]    rd_data, status_word;
   logic           maint_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   vmaint_status_gen #(.N_LR(N), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .en_g1_off(en_g1_off), .en_g1_on(en_g1_on),
      .en_g0_off(en_g0_off), .en_g0_on(en_g0_on),
      .en_nopend(en_nopend), .en_cnt_nz(en_cnt_nz), .en_underflow(en_underflow),
      .vgrp0_on(vgrp0_on), .vgrp1_on(vgrp1_on),
      .lr_state(lr_state), .lr_hw(lr_hw), .lr_eoi_req(lr_eoi_req),
      .eoi_count(eoi_count), .maint_en(maint_en),
      .rd_priv(rd_priv), .nest_trap(nest_trap), .sre_hyp(sre_hyp), .sre_mon(sre_mon),
      .rd_result(rd_result), .rd_trap_level(rd_trap_level), .rd_syndrome(rd_syndrome),
      .rd_data(rd_data), .status_word(status_word), .maint_irq(maint_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      en_g1_off = 0; en_g1_on = 0; en_g0_off = 0; en_g0_on = 0;
      en_nopend = 0; en_cnt_nz = 0; en_underflow = 0;
      vgrp0_on = 0; vgrp1_on = 0;
      lr_state = '0; lr_hw = '0; lr_eoi_req = '0; eoi_count = '0;
      maint_en = 0; rd_priv = 2'd2; nest_trap = 0; sre_hyp = 1; sre_mon = 1;
   endtask

   // one rising edge, then sample at the following falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 0;
      clear_inputs();
      en_underflow = 1;
      maint_en = 1;
      step(); step();
      chk("R9 status in reset", status_word, 64'h0);
      chk("R9 irq in reset", {63'h0, maint_irq}, 64'h0);
      en_underflow = 0;
      maint_en = 0;
      rst_n = 1;
      step();
      chk("R9 status after release", status_word, 64'h0);
   endtask

   task automatic t_groups();
      clear_inputs();
      en_g1_off = 1; en_g1_on = 1; en_g0_off = 1; en_g0_on = 1;
      vgrp1_on = 0; vgrp0_on = 1;
      step();
      chk("R2/R3 g1 off g0 on", status_word, 64'h90);
      vgrp1_on = 1; vgrp0_on = 0;
      step();
      chk("R2/R3 g1 on g0 off", status_word, 64'h60);
      en_g1_on = 0; en_g0_off = 0;
      step();
      chk("R2/R3 enables cleared", status_word, 64'h00);
   endtask

   task automatic t_pending();
      clear_inputs();
      en_nopend = 1;
      step();
      chk("R4 all invalid", status_word, 64'h08);
      lr_state = 8'b00_01_00_00;
      step();
      chk("R4 entry2 pending", status_word, 64'h00);
      lr_state = 8'b00_11_00_00;
      step();
      chk("R4 entry2 pend+active", status_word, 64'h00);
      lr_state = 8'b10_10_10_10;
      step();
      chk("R4 all active", status_word, 64'h08);
   endtask

   task automatic t_count();
      clear_inputs();
      en_cnt_nz = 1;
      step();
      chk("R5 count zero", status_word, 64'h00);
      eoi_count = 5'd1;
      step();
      chk("R5 count one", status_word, 64'h04);
      eoi_count = 5'd31;
      step();
      chk("R5 count max", status_word, 64'h04);
   endtask

   task automatic t_underflow();
      clear_inputs();
      en_underflow = 1;
      step();
      chk("R6 none valid", status_word, 64'h02);
      lr_state = 8'b00_00_10_00;
      step();
      chk("R6 one valid", status_word, 64'h02);
      lr_state = 8'b01_00_10_00;
      step();
      chk("R6 two valid", status_word, 64'h00);
      lr_state = 8'b00_00_00_00;
      en_underflow = 0;
      step();
      chk("R6 enable off", status_word, 64'h00);
   endtask

   task automatic t_eoi();
      clear_inputs();
      lr_eoi_req = 4'b0010;
      step();
      chk("R7 invalid req no hw", status_word, 64'h01);
      lr_hw = 4'b0010;
      step();
      chk("R7 hw flag set", status_word, 64'h00);
      lr_hw = 4'b0000;
      lr_state = 8'b00_00_10_00;
      step();
      chk("R7 entry not invalid", status_word, 64'h00);
      lr_eoi_req = 4'b1010;
      step();
      chk("R7 entry3 qualifies", status_word, 64'h01);
   endtask

   task automatic t_irq();
      clear_inputs();
      lr_eoi_req = 4'b0001;
      step();
      chk("R8 gated off", {63'h0, maint_irq}, 64'h0);
      maint_en = 1;
      #1;
      chk("R8 one-cycle latency", {63'h0, maint_irq}, 64'h0);
      step();
      chk("R8 irq raised", {63'h0, maint_irq}, 64'h1);
      en_g1_off = 1; en_g1_on = 1; en_g0_off = 1; en_g0_on = 1;
      en_nopend = 1; en_cnt_nz = 1; en_underflow = 1; eoi_count = 5'd2;
      step();
      chk("R1 upper bits zero", {8'h0, status_word[63:8]}, 64'h0);
      chk("R1 low byte order", status_word, 64'hAF);
      lr_eoi_req = '0; en_g1_off = 0; en_g1_on = 0; en_g0_off = 0; en_g0_on = 0;
      en_nopend = 0; en_cnt_nz = 0; en_underflow = 0;
      step();
      chk("R8 irq drops with no cause", {63'h0, maint_irq}, 64'h0);
   endtask

   task automatic t_access();
      clear_inputs();
      en_cnt_nz = 1; eoi_count = 5'd3; en_g0_on = 1; vgrp0_on = 1;
      step();
      rd_priv = 2'd0; #1;
      chk("R10 level0 result", {62'h0, rd_result}, 64'd1);
      chk("R10 level0 data", rd_data, 64'h0);
      rd_priv = 2'd1; nest_trap = 0; #1;
      chk("R11 level1 undefined", {62'h0, rd_result}, 64'd1);
      nest_trap = 1; #1;
      chk("R11 level1 trap", {52'h0, rd_result, rd_trap_level, rd_syndrome}, {52'h0, 2'd2, 2'd2, 6'h18});
      rd_priv = 2'd2; sre_hyp = 0; #1;
      chk("R12 level2 trap", {52'h0, rd_result, rd_trap_level, rd_syndrome}, {52'h0, 2'd2, 2'd2, 6'h18});
      sre_hyp = 1; #1;
      chk("R12 level2 read", {52'h0, rd_result, rd_trap_level, rd_syndrome}, 64'h0);
      chk("R12 level2 data", rd_data, 64'h14);
      rd_priv = 2'd3; sre_mon = 0; #1;
      chk("R12 level3 trap", {52'h0, rd_result, rd_trap_level, rd_syndrome}, {52'h0, 2'd2, 2'd3, 6'h18});
      sre_mon = 1; #1;
      chk("R12 level3 data", rd_data, 64'h14);
      // same-cycle input change and read: old word until the edge
      @(negedge clk);
      en_g0_on = 0;
      #1;
      chk("R12 read before edge", rd_data, 64'h14);
      step();
      chk("R12 read after edge", rd_data, 64'h04);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_groups();
      t_pending();
      t_count();
      t_underflow();
      t_eoi();
      t_irq();
      t_access();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule